// File: doc/BRIEF.md
# I/O Instruction Retry Threshold Controller

This block chooses the recovery path when a hardware error strikes during execution of an I/O instruction. When an instruction begins, the sequencer reports its type code. While the instruction runs, the sequencer also reports a progress step. The block keeps one programmable threshold step per instruction type. An error seen while the progress step is still below the threshold of the running type makes the block ask the sequencer to restart the instruction. No software is involved in that restart. If the instruction then completes, the block issues a machine-check request whose only purpose is recording.

An error at or beyond the threshold abandons hardware recovery. So does an error on the last permitted attempt. In both cases the block issues an I/O interrupt request, so that device-specific software recovery can take over. Each of the three requests is a single-cycle pulse and is registered, so it appears one cycle after the event that causes it.

Top module: `iorty_ctrl`

## Requirements
- R1: The block holds one threshold per type code. All thresholds reset to RST_THR (default 4). A write (`thr_wr` high) updates the threshold of `thr_wr_type` at the next clock edge. Writes to other types leave a threshold unchanged.
- R2: An error can be retried when all three of these hold: the block is busy, `prog_step` is below the threshold of the latched type, and fewer than MAX_TRIES (default 2) executions have been started. Such an error makes `restart_req` high for one cycle on the following cycle.
- R3: `ins_done` while busy and after at least one restart gives a one-cycle `mchk_req` on the following cycle. `ins_done` with no prior restart gives no `mchk_req`.
- R4: An error while `prog_step` is at or above the threshold gives a one-cycle `io_int_req` on the following cycle. The block then returns to idle.
- R5: Type code 0 (start I/O) with its reset threshold retries errors at steps 0 to 3, which are the steps before the device is engaged. It does not retry an error at step 4.
- R6: `mchk_req` and `io_int_req` are never high together. Each request lasts exactly one cycle. After either request the block is idle.
- R7: A further error below the threshold, seen once the last permitted execution has started (the second execution, by default), gives `io_int_req` and no `restart_req`.
- R8: While idle, `err_strobe` and `ins_done` produce no request. While busy, `ins_start` is ignored and the latched type is kept.
- R9: When `err_strobe` and `ins_done` arrive in the same cycle, the error is handled and the completion is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr | input | 1 | Threshold table write strobe |
| thr_wr_type | input | TYPE_W | Type code whose threshold is written |
| thr_wr_step | input | STEP_W | New threshold step |
| ins_start | input | 1 | Instruction begins (accepted when idle) |
| ins_type | input | TYPE_W | Type code of the starting instruction |
| prog_step | input | STEP_W | Current progress step from the sequencer |
| err_strobe | input | 1 | Hardware error seen this cycle |
| ins_done | input | 1 | Instruction completed this cycle |
| restart_req | output | 1 | Restart the instruction (one-cycle pulse) |
| mchk_req | output | 1 | Recording-only machine-check request (pulse) |
| io_int_req | output | 1 | I/O interrupt request for software recovery (pulse) |

## Verification
The bench builds the block with its default parameters: 3-bit types, 4-bit steps, MAX_TRIES of 2 and a reset threshold of 4. With 4-bit steps, every step value can be driven, so thresholds of 0 (never retry) and 15 can both be reached, as can errors exactly at the threshold. With MAX_TRIES of 2, the retry-limit abort is reached after only two errors. This lets the random traffic hit the abort path often, alongside table writes made while an instruction is running.

// File: rtl/iorty_pkg.sv
package iorty_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} iorty_st_t;

  // Retry is possible only strictly before the threshold step
  function automatic logic step_below(input logic [7:0] step, input logic [7:0] thr);
    return step < thr;
  endfunction

  // Another attempt is allowed while started executions are under the limit
  function automatic logic tries_left(input logic [7:0] tries, input logic [7:0] lim);
    return tries < lim;
  endfunction
endpackage

// File: rtl/iorty_thr_table.sv
module iorty_thr_table #(
  parameter int TYPE_W  = 3,
  parameter int STEP_W  = 4,
  parameter int RST_THR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TYPE_W-1:0] wtype,
  input  logic [STEP_W-1:0] wstep,
  input  logic [TYPE_W-1:0] rtype,
  output logic [STEP_W-1:0] rstep
);
  localparam int NTYPES = 1 << TYPE_W;

  logic [STEP_W-1:0] thr_q [NTYPES];

  generate
    for (genvar g = 0; g < NTYPES; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n)                            thr_q[g] <= STEP_W'(RST_THR);
        else if (we && wtype == TYPE_W'(g))    thr_q[g] <= wstep;
      end
    end
  endgenerate

  assign rstep = thr_q[rtype];
endmodule

// File: rtl/iorty_seq.sv
module iorty_seq #(
  parameter int TYPE_W    = 3,
  parameter int MAX_TRIES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] start_type,
  input  logic              err,
  input  logic              done,
  input  logic              below_thr,
  output logic              busy,
  output logic [TYPE_W-1:0] cur_type,
  output logic              ev_retry,
  output logic              ev_abort,
  output logic              ev_record,
  output logic              restart_q,
  output logic              mchk_q,
  output logic              ioint_q
);
  import iorty_pkg::*;
  localparam int CNT_W = $clog2(MAX_TRIES + 1);

  iorty_st_t        st_q;
  logic [CNT_W-1:0] tries_q;
  logic             ev_finish;

  assign busy      = (st_q == ST_RUN);
  assign ev_retry  = busy && err && below_thr &&
                     tries_left(8'(tries_q), 8'(MAX_TRIES));
  assign ev_abort  = busy && err && !ev_retry;
  assign ev_finish = busy && !err && done;
  assign ev_record = ev_finish && (tries_q > CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tries_q   <= '0;
      cur_type  <= '0;
      restart_q <= 1'b0;
      mchk_q    <= 1'b0;
      ioint_q   <= 1'b0;
    end else begin
      restart_q <= ev_retry;
      mchk_q    <= ev_record;
      ioint_q   <= ev_abort;
      if (!busy && start) begin
        st_q     <= ST_RUN;
        cur_type <= start_type;
        tries_q  <= CNT_W'(1);
      end else if (ev_abort || ev_finish) begin
        st_q <= ST_IDLE;
      end else if (ev_retry) begin
        tries_q <= tries_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/iorty_ctrl.sv
module iorty_ctrl #(
  parameter int TYPE_W    = 3,
  parameter int STEP_W    = 4,
  parameter int MAX_TRIES = 2,
  parameter int RST_THR   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic [TYPE_W-1:0] thr_wr_type,
  input  logic [STEP_W-1:0] thr_wr_step,
  input  logic              ins_start,
  input  logic [TYPE_W-1:0] ins_type,
  input  logic [STEP_W-1:0] prog_step,
  input  logic              err_strobe,
  input  logic              ins_done,
  output logic              restart_req,
  output logic              mchk_req,
  output logic              io_int_req
);
  import iorty_pkg::*;

  logic [TYPE_W-1:0] cur_type;
  logic [STEP_W-1:0] cur_thr;
  logic              below_thr;
  logic              busy;
  logic              ev_retry, ev_abort, ev_record;

  iorty_thr_table #(.TYPE_W(TYPE_W), .STEP_W(STEP_W), .RST_THR(RST_THR)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(thr_wr), .wtype(thr_wr_type),
    .wstep(thr_wr_step), .rtype(cur_type), .rstep(cur_thr)
  );

  assign below_thr = step_below(8'(prog_step), 8'(cur_thr));

  iorty_seq #(.TYPE_W(TYPE_W), .MAX_TRIES(MAX_TRIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(ins_start), .start_type(ins_type),
    .err(err_strobe), .done(ins_done), .below_thr(below_thr),
    .busy(busy), .cur_type(cur_type), .ev_retry(ev_retry),
    .ev_abort(ev_abort), .ev_record(ev_record),
    .restart_q(restart_req), .mchk_q(mchk_req), .ioint_q(io_int_req)
  );
endmodule

// File: rtl/iorty_chk.sv
module iorty_chk (
  input logic clk,
  input logic rst_n,
  input logic err_strobe,
  input logic ins_done,
  input logic busy,
  input logic restart_req,
  input logic mchk_req,
  input logic io_int_req
);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mchk_req && io_int_req));
  assert_mchk_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req |=> !mchk_req);
  assert_io_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_int_req |=> !io_int_req);
  assert_restart_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> ($past(err_strobe) && $past(busy) && busy));
  assert_io_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_int_req |-> ($past(err_strobe) && $past(busy) && !busy));
  assert_mchk_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req |-> ($past(ins_done) && !$past(err_strobe) && !busy));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !(restart_req || mchk_req || io_int_req));
endmodule

bind iorty_ctrl iorty_chk u_chk (.*);

// File: tb/sim_iorty_ctrl.sv
module sim_iorty_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, thr_wr, ins_start, err_strobe, ins_done;
  logic [2:0] thr_wr_type, ins_type;
  logic [3:0] thr_wr_step, prog_step;
  logic       restart_req, mchk_req, io_int_req;

  iorty_ctrl u0 (.*);

  int n_cmp = 0, n_bad = 0;
  logic [3:0] m_thr [8];
  logic       m_busy;
  logic [2:0] m_typ;
  int         m_tries;

  function automatic logic can_retry(input logic [3:0] sp, input logic [3:0] th, input int tr);
    return (int'(sp) < int'(th)) && (tr < 2);
  endfunction

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic we, input logic [2:0] wt, input logic [3:0] ws,
                     input logic st, input logic [2:0] ty, input logic [3:0] sp,
                     input logic er, input logic dn);
    logic e_rs, e_mc, e_io;
    @(negedge clk);
    thr_wr = we; thr_wr_type = wt; thr_wr_step = ws;
    ins_start = st; ins_type = ty; prog_step = sp; err_strobe = er; ins_done = dn;
    e_rs = 0; e_mc = 0; e_io = 0;
    if (m_busy && er) begin
      if (can_retry(sp, m_thr[m_typ], m_tries)) e_rs = 1; else e_io = 1;
    end else if (m_busy && dn) e_mc = (m_tries > 1);
    if (!m_busy && st) begin m_busy = 1; m_typ = ty; m_tries = 1; end
    else if (m_busy && er) begin if (e_rs) m_tries++; else m_busy = 0; end
    else if (m_busy && dn) m_busy = 0;
    if (we) m_thr[wt] = ws;
    @(posedge clk); #1;
    chk(tag, "restart_req", restart_req, e_rs);
    chk(tag, "mchk_req", mchk_req, e_mc);
    chk(tag, "io_int_req", io_int_req, e_io);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1A2B;
    void'($urandom(seed));
    rst_n = 0; thr_wr = 0; thr_wr_type = 0; thr_wr_step = 0;
    ins_start = 0; ins_type = 0; prog_step = 0; err_strobe = 0; ins_done = 0;
    for (int i = 0; i < 8; i++) m_thr[i] = 4'd4;
    m_busy = 0; m_typ = 0; m_tries = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset", "restart_req", restart_req, 0);
    chk("R6 reset", "mchk_req", mchk_req, 0);
    chk("R6 reset", "io_int_req", io_int_req, 0);
    @(negedge clk); rst_n = 1;

    // R8: idle ignores error and done
    cyc("R8 idle err", 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R8 idle done", 0, 0, 0, 0, 0, 1, 0, 1);
    // R5/R2/R3: start I/O, error at step 3, retry, then success recorded
    cyc("R5 start", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R5 err step3", 0, 0, 0, 0, 0, 3, 1, 0);
    cyc("R2 rerun", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R3 done after retry", 0, 0, 0, 0, 0, 5, 0, 1);
    idle("R6 back idle");
    // R5/R4: error at step 4 equals threshold
    cyc("R5 start", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R4 err at thr", 0, 0, 0, 0, 0, 4, 1, 0);
    cyc("R8 after abort", 0, 0, 0, 0, 0, 0, 1, 1);
    // R7: two errors below threshold
    cyc("R7 start", 0, 0, 0, 1, 2, 0, 0, 0);
    cyc("R7 err1", 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R7 err2", 0, 0, 0, 0, 0, 1, 1, 0);
    // R3: done without retry gives nothing
    cyc("R3 start", 0, 0, 0, 1, 1, 0, 0, 0);
    cyc("R3 plain done", 0, 0, 0, 0, 0, 2, 0, 1);
    // R1: thresholds 0 and 15
    cyc("R1 wr5=0", 1, 5, 0, 0, 0, 0, 0, 0);
    cyc("R1 wr6=15", 1, 6, 15, 0, 0, 0, 0, 0);
    cyc("R1 start5", 0, 0, 0, 1, 5, 0, 0, 0);
    cyc("R1 thr0 err", 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R1 start6", 0, 0, 0, 1, 6, 0, 0, 0);
    cyc("R1 thr15 err14", 0, 0, 0, 0, 0, 14, 1, 0);
    // R9: err and done together; R8: start while busy ignored
    cyc("R8 start while busy", 0, 0, 0, 1, 5, 0, 0, 0);
    cyc("R9 err+done", 0, 0, 0, 0, 0, 15, 1, 1);

    // Random traffic: R1 R2 R3 R4 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      logic we, st, er, dn;
      we = ($urandom % 10) == 0;
      st = ($urandom % 4) == 0;
      er = ($urandom % 5) == 0;
      dn = ($urandom % 6) == 0;
      cyc("R2/R3/R4/R7 random", we, 3'($urandom), 4'($urandom), st, 3'($urandom),
          4'($urandom % 8), er, dn);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule